// File: doc/BRIEF.md
# Dual-rail minterm lookup node

This block is one node of a delay-insensitive network. Its function of K inputs is set by a truth-table parameter, so it can stand in for any K-input gate. Every input and the output travel as a pair of rails. On each pair, `hi`=1/`lo`=0 carries logic 1, `hi`=0/`lo`=1 carries logic 0, both low is the spacer (null), and both high is forbidden.

Inside the node there is one C-element for each of the 2^K minterms. Each C-element watches the rails that spell its minterm. A C-element rises when all the rails it watches are high, falls when all of them are low, and otherwise keeps its state. The C-element outputs are ORed into the high rail or the low rail of the output, as the truth table selects. This is a synchronous model: each C-element state is a flip-flop that updates on the clock edge.

The node follows a four-phase handshake under strong constraints. The output turns valid only after every input is valid. It goes back to spacer only after every input has returned to spacer. A combinational flag reports any input pair that shows the forbidden code.

Top module: `dims_lut`

## Requirements
- R1: Once valid, the output carries bit v of `TT`, where bit i of v is the logic value of input i. Logic 1 is `out_hi`=1, `out_lo`=0. Logic 0 is `out_hi`=0, `out_lo`=1.
- R2: While at least one input pair is still spacer, an output that is spacer stays spacer.
- R3: Once the output is valid, it stays unchanged while at least one input pair is not spacer.
- R4: The output returns to spacer on the clock edge after every input pair reads 00. It never returns at any other time.
- R5: The output turns valid on the first clock edge at which every input pair holds a valid code.
- R6: The output pair never shows 11.
- R7: `code_err` is high in the same cycle that any input pair shows 11, and low when no pair does.
- R8: While `rst_n` is low, and right after it, the output is spacer (00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the C-element state |
| rst_n | input | 1 | Active-low synchronous reset, clears every C-element |
| in_hi | input | K | True rail of each input |
| in_lo | input | K | False rail of each input |
| out_hi | output | 1 | True rail of the output |
| out_lo | output | 1 | False rail of the output |
| code_err | output | 1 | Some input pair shows the forbidden 11 code |

## Verification
The bench builds the node with K=3 and TT=8'hCA. That table is a multiplexer and is not symmetric in its inputs, so a swapped rail or a wrong minterm bit order changes the output for some of the eight input words. All eight words are driven through full handshakes. Inputs arrive and leave in a random order with random gaps, and several may change in the same cycle. This exposes any output that moves on a partial set of inputs, in either phase.

// File: rtl/dims_lut.sv
module dims_lut #(
  parameter int K = 3,
  parameter logic [(1<<K)-1:0] TT = 8'hCA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] in_hi,
  input  logic [K-1:0] in_lo,
  output logic         out_hi,
  output logic         out_lo,
  output logic         code_err
);
  localparam int M = 1 << K;

  logic [M-1:0] c_q;

  genvar m, i;
  generate
    for (m = 0; m < M; m++) begin : g_mint
      logic [K-1:0] leg;
      logic         c_bit;
      for (i = 0; i < K; i++) begin : g_leg
        if (((m >> i) & 1) == 1) begin : g_t
          assign leg[i] = in_hi[i];
        end else begin : g_f
          assign leg[i] = in_lo[i];
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n)       c_bit <= 1'b0;
        else if (&leg)    c_bit <= 1'b1;
        else if (~|leg)   c_bit <= 1'b0;
      end
      assign c_q[m] = c_bit;
    end
  endgenerate

  assign out_hi   = |(c_q & TT);
  assign out_lo   = |(c_q & ~TT);
  assign code_err = |(in_hi & in_lo);
endmodule

// File: rtl/dims_lut_chk.sv
module dims_lut_chk #(
  parameter int K = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [K-1:0] in_hi,
  input logic [K-1:0] in_lo,
  input logic         out_hi,
  input logic         out_lo
);
  logic all_valid, all_null, out_busy;
  assign all_valid = &(in_hi ^ in_lo);
  assign all_null  = (in_hi == '0) && (in_lo == '0);
  assign out_busy  = out_hi | out_lo;

  assert_no_forbidden_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hi && out_lo));

  assert_rise_after_all_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_busy) |-> $past(all_valid));

  assert_fall_after_all_null_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_busy) |-> $past(all_null));

  assert_hold_until_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_busy && !all_null) |=> ($stable(out_hi) && $stable(out_lo)));
endmodule

bind dims_lut dims_lut_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_hi(in_hi), .in_lo(in_lo),
  .out_hi(out_hi), .out_lo(out_lo)
);

// File: tb/dims_lut_bench.sv
`timescale 1ns/100ps
module dims_lut_bench;
  localparam int K = 3;
  localparam logic [7:0] TT = 8'hCA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [K-1:0] in_hi = '0, in_lo = '0;
  logic out_hi, out_lo, code_err;

  int checks = 0, fails = 0;
  bit finished = 1'b0, cmp_en = 1'b0;
  string tag = "R2";
  logic exp_hi = 1'b0, exp_lo = 1'b0;

  always #2.5 clk = ~clk;

  dims_lut #(.K(K), .TT(TT)) u_dims_lut (
    .clk(clk), .rst_n(rst_n), .in_hi(in_hi), .in_lo(in_lo),
    .out_hi(out_hi), .out_lo(out_lo), .code_err(code_err)
  );

  // reference: output follows a completed input word, clears on all-null, else holds
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_hi <= 1'b0; exp_lo <= 1'b0;
    end else if (&(in_hi ^ in_lo)) begin
      exp_hi <= TT[in_hi]; exp_lo <= !TT[in_hi];
    end else if (in_hi == '0 && in_lo == '0) begin
      exp_hi <= 1'b0; exp_lo <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk)
    if (cmp_en && rst_n) check(tag, {out_hi, out_lo}, {exp_hi, exp_lo});

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic arrive(input logic [K-1:0] v);
    logic [K-1:0] done = '0;
    tag = "R2";
    while (done != '1) begin
      int idx = $urandom % K;
      if (!done[idx]) begin
        in_hi[idx] = v[idx];
        in_lo[idx] = !v[idx];
        done[idx] = 1'b1;
        if (done != '1) repeat ($urandom % 3) step();
      end
    end
    tag = "R5";
  endtask

  task automatic leave;
    logic [K-1:0] gone = '0;
    tag = "R3";
    while (gone != '1) begin
      int idx = $urandom % K;
      if (!gone[idx]) begin
        in_hi[idx] = 1'b0;
        in_lo[idx] = 1'b0;
        gone[idx] = 1'b1;
        if (gone != '1) repeat ($urandom % 3) step();
      end
    end
    tag = "R4";
  endtask

  initial begin
    #50000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    repeat (3) step();
    check("R8", {out_hi, out_lo}, 2'b00);
    rst_n = 1'b1;
    step();
    check("R8", {out_hi, out_lo}, 2'b00);
    check("R7", {1'b0, code_err}, 2'b00);
    cmp_en = 1'b1;
    for (int rep = 0; rep < 6; rep++) begin
      for (int v = 0; v < (1 << K); v++) begin
        arrive(v[K-1:0]);
        step();
        check("R1", {out_hi, out_lo}, {TT[v], !TT[v]});
        check("R7", {1'b0, code_err}, 2'b00);
        tag = "R3";
        repeat ($urandom % 3) step();
        leave();
        step();
        check("R4", {out_hi, out_lo}, 2'b00);
        repeat ($urandom % 2) step();
      end
    end
    tag = "R6";
    in_hi[1] = 1'b1; in_lo[1] = 1'b1;
    #1 check("R7", {1'b0, code_err}, 2'b01);
    repeat (2) step();
    check("R6", {out_hi, out_lo}, 2'b00);
    in_hi[1] = 1'b0; in_lo[1] = 1'b0;
    #1 check("R7", {1'b0, code_err}, 2'b00);
    step();
    rst_n = 1'b0;
    arrive(3'b101);
    tag = "R8";
    step(); step();
    cmp_en = 1'b0;
    check("R8", {out_hi, out_lo}, 2'b00);
    report();
  end
endmodule